// File: doc/BRIEF.md
# Dual-Class Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines and presents two request outputs to a processor core: a normal request and a fast request. Each hardware line is synchronized into the clock domain and then combined, by OR, with a software force bit. The result is one source bit per line.

Two independent enable masks steer every source bit into the normal class, the fast class, both classes, or neither. Each class has its own pending word, which is the source word ANDed with that class's enable mask. Each class also has a request line, which is the OR of that pending word.

Software reaches the block through a simple 32-bit word bus. The two enable masks and the force word can be written. Every register can be read. Any access that is not a full word, or that targets an unused offset, is ignored on writes and reads back as zero.

Top module: `dual_class_irq_ctrl`

## Requirements
- R1: After reset, both enable masks and the force word are zero, and both `irq_normal` and `irq_fast` are low.
- R2: The source word, read at offset 0x00, equals the synchronized hardware lines ORed with the force word. A hardware level reaches it after SYNC_STAGES rising clock edges.
- R3: The normal pending word, read at offset 0x0C, equals the source word ANDed with the normal enable mask.
- R4: `irq_normal` is high exactly when at least one normal pending bit is set.
- R5: The fast pending word, read at offset 0x10, equals the source word ANDed with the fast enable mask.
- R6: `irq_fast` is high exactly when at least one fast pending bit is set.
- R7: The normal enable mask (offset 0x04) and the fast enable mask (offset 0x08) take the written data on a full-word write, and read back what was written.
- R8: Writes to offsets 0x00, 0x0C and 0x10 change no register contents and no request output.
- R9: The force word (offset 0x14) can be read and written. A set force bit raises its source bit, and so the enabled requests, with no hardware line asserted. The request shows in the cycle after the write edge.
- R10: An access whose byte enables (`bus_be`) are not all ones is ignored on a write and returns zero on a read.
- R11: An access to any offset other than the six listed is ignored on a write and returns zero on a read.
- R12: A source enabled in both masks drives `irq_normal` and `irq_fast` at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Level-sensitive hardware request lines |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_be | input | DATA_W/8 | Byte enables; only all ones is a valid access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| irq_normal | output | 1 | Normal-class request to the core |
| irq_fast | output | 1 | Fast-class request to the core |

## Verification
The pending and request paths are driven with a single hardware line, with a scattered multi-bit pattern, and with all lines high. Each pattern is run against enable masks that overlap it partly, fully, or not at all. This separates a correct AND-then-OR from a plain OR of the sources or an unmasked path. Normal-only, fast-only and shared enables show whether the two classes are kept apart. Force-only stimulus with the hardware lines held low shows that the software path reaches the source word. Partial-word, unmapped and read-only writes are each followed by read-back and request checks, which show that nothing was disturbed.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
   localparam int OFS_SRC   = 'h00;
   localparam int OFS_NEN   = 'h04;
   localparam int OFS_FEN   = 'h08;
   localparam int OFS_NPND  = 'h0C;
   localparam int OFS_FPND  = 'h10;
   localparam int OFS_FORCE = 'h14;

   typedef enum logic [2:0] {
      SEL_SRC,
      SEL_NEN,
      SEL_FEN,
      SEL_NPND,
      SEL_FPND,
      SEL_FORCE,
      SEL_NONE
   } reg_sel_e;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("irq_line_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/irq_class_gate.sv
module irq_class_gate #(
   parameter int W = 32
) (
   input  logic [W-1:0] src,
   input  logic [W-1:0] en,
   output logic [W-1:0] pend,
   output logic         req
);
   assign pend = src & en;
   assign req  = |pend;
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
   import irq_ctl_pkg::*;
#(
   parameter int W      = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W/8-1:0] bus_be,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [W-1:0]      src,
   input  logic [W-1:0]      npend,
   input  logic [W-1:0]      fpend,
   output logic [W-1:0]      nen_q,
   output logic [W-1:0]      fen_q,
   output logic [W-1:0]      force_q
);
   localparam int BE_W = DATA_W / 8;

   reg_sel_e sel;
   logic     full_word;
   logic     wr_ok;

   assign full_word = (bus_be == {BE_W{1'b1}});
   assign wr_ok     = bus_sel && bus_wr && full_word;

   always_comb begin
      if      (bus_addr == ADDR_W'(OFS_SRC))   sel = SEL_SRC;
      else if (bus_addr == ADDR_W'(OFS_NEN))   sel = SEL_NEN;
      else if (bus_addr == ADDR_W'(OFS_FEN))   sel = SEL_FEN;
      else if (bus_addr == ADDR_W'(OFS_NPND))  sel = SEL_NPND;
      else if (bus_addr == ADDR_W'(OFS_FPND))  sel = SEL_FPND;
      else if (bus_addr == ADDR_W'(OFS_FORCE)) sel = SEL_FORCE;
      else                                     sel = SEL_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nen_q   <= '0;
         fen_q   <= '0;
         force_q <= '0;
      end else if (wr_ok) begin
         case (sel)
            SEL_NEN:   nen_q   <= bus_wdata[W-1:0];
            SEL_FEN:   fen_q   <= bus_wdata[W-1:0];
            SEL_FORCE: force_q <= bus_wdata[W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr && full_word) begin
         case (sel)
            SEL_SRC:   bus_rdata = DATA_W'(src);
            SEL_NEN:   bus_rdata = DATA_W'(nen_q);
            SEL_FEN:   bus_rdata = DATA_W'(fen_q);
            SEL_NPND:  bus_rdata = DATA_W'(npend);
            SEL_FPND:  bus_rdata = DATA_W'(fpend);
            SEL_FORCE: bus_rdata = DATA_W'(force_q);
            default:   bus_rdata = '0;
         endcase
      end
   end

   // R7: an enable mask holds its value unless a valid full-word write targets it
   a_r7_nen_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ok && bus_addr == ADDR_W'(OFS_NEN)) |=> $stable(nen_q));
   a_r7_fen_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && bus_addr == ADDR_W'(OFS_FEN)) |=> fen_q == $past(bus_wdata[W-1:0]));
   // R10: a write with partial byte enables leaves every writable register unchanged
   a_r10_partial_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !full_word) |=> ($stable(nen_q) && $stable(fen_q) && $stable(force_q)));
   // R10: a read with partial byte enables returns zero
   a_r10_partial_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && !full_word) |-> bus_rdata == '0);
endmodule

// File: rtl/dual_class_irq_ctrl.sv
module dual_class_irq_ctrl #(
   parameter int NUM_SRC     = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  irq_in,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W/8-1:0] bus_be,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq_normal,
   output logic                irq_fast
);
   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("dual_class_irq_ctrl: NUM_SRC must be within 1..DATA_W");
      end
      if (DATA_W % 8 != 0) begin : g_bad_data
         $error("dual_class_irq_ctrl: DATA_W must be a multiple of 8");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("dual_class_irq_ctrl: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [NUM_SRC-1:0] hw_sync;
   logic [NUM_SRC-1:0] src;
   logic [NUM_SRC-1:0] nen_q, fen_q, force_q;
   logic [NUM_SRC-1:0] npend, fpend;

   irq_line_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_in), .q(hw_sync)
   );

   assign src = hw_sync | force_q;

   irq_class_gate #(.W(NUM_SRC)) u_normal (
      .src(src), .en(nen_q), .pend(npend), .req(irq_normal)
   );

   irq_class_gate #(.W(NUM_SRC)) u_fast (
      .src(src), .en(fen_q), .pend(fpend), .req(irq_fast)
   );

   irq_reg_bank #(.W(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src(src), .npend(npend), .fpend(fpend),
      .nen_q(nen_q), .fen_q(fen_q), .force_q(force_q)
   );

   // R6: with no fast enable set, the fast request stays low
   a_r6_fast_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (fen_q == '0) |-> !irq_fast);
   // R4: with no normal enable set, the normal request stays low
   a_r4_normal_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (nen_q == '0) |-> !irq_normal);
   // R9: forcing a normally enabled bit raises the normal request next cycle
   a_r9_force_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_be == '1 && bus_addr == ADDR_W'(irq_ctl_pkg::OFS_FORCE)
       && ((bus_wdata[NUM_SRC-1:0] & nen_q) != '0)) |=> irq_normal);
endmodule

// File: tb/tb_dual_class_irq_ctrl.sv
module tb_dual_class_irq_ctrl;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] irq_in = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_normal, irq_fast;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   dual_class_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_normal(irq_normal), .irq_fast(irq_fast)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic bus_read(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0; bus_be = '0;
   endtask

   task automatic set_hw(input logic [N-1:0] v);
      @(negedge clk);
      irq_in = v;
      repeat (2) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] r;
      check("R1 irq_normal after reset", {31'd0, irq_normal}, 32'd0);
      check("R1 irq_fast after reset", {31'd0, irq_fast}, 32'd0);
      bus_read(8'h04, 4'hF, r); check("R1 normal enable reset", r, 32'd0);
      bus_read(8'h08, 4'hF, r); check("R1 fast enable reset", r, 32'd0);
      bus_read(8'h14, 4'hF, r); check("R1 force reset", r, 32'd0);
   endtask

   task automatic t_enable_rw();
      logic [31:0] r;
      bus_write(8'h04, 32'hA5A5_0F0F, 4'hF);
      bus_write(8'h08, 32'h1234_8001, 4'hF);
      bus_read(8'h04, 4'hF, r); check("R7 normal enable readback", r, 32'hA5A5_0F0F);
      bus_read(8'h08, 4'hF, r); check("R7 fast enable readback", r, 32'h1234_8001);
      bus_write(8'h04, 32'd0, 4'hF);
      bus_write(8'h08, 32'd0, 4'hF);
   endtask

   task automatic t_normal_path();
      logic [31:0] r;
      logic [31:0] pats [3];
      logic [31:0] ens  [3];
      pats[0] = 32'h0000_0010; pats[1] = 32'h8421_0C03; pats[2] = 32'hFFFF_FFFF;
      ens[0]  = 32'h0000_0010; ens[1]  = 32'h0000_F000; ens[2]  = 32'h0101_0000;
      for (int p = 0; p < 3; p++) begin
         for (int e = 0; e < 3; e++) begin
            bus_write(8'h04, ens[e], 4'hF);
            set_hw(pats[p]);
            bus_read(8'h00, 4'hF, r); check("R2 source word", r, pats[p]);
            bus_read(8'h0C, 4'hF, r); check("R3 normal pending", r, pats[p] & ens[e]);
            check("R4 irq_normal", {31'd0, irq_normal}, {31'd0, |(pats[p] & ens[e])});
            check("R6 irq_fast stays low", {31'd0, irq_fast}, 32'd0);
         end
      end
      bus_write(8'h04, 32'd0, 4'hF);
      set_hw('0);
   endtask

   task automatic t_sync_latency();
      logic [31:0] r;
      bus_write(8'h04, 32'h0000_0004, 4'hF);
      @(negedge clk); irq_in = 32'h0000_0004;
      @(posedge clk); @(negedge clk);
      check("R2 not visible after one edge", {31'd0, irq_normal}, 32'd0);
      @(posedge clk); @(negedge clk);
      check("R2 visible after two edges", {31'd0, irq_normal}, 32'd1);
      bus_read(8'h00, 4'hF, r); check("R2 source after sync", r, 32'h0000_0004);
      bus_write(8'h04, 32'd0, 4'hF);
      set_hw('0);
   endtask

   task automatic t_fast_path();
      logic [31:0] r;
      bus_write(8'h08, 32'h00F0_0000, 4'hF);
      set_hw(32'h0030_0101);
      bus_read(8'h10, 4'hF, r); check("R5 fast pending", r, 32'h0030_0000);
      check("R6 irq_fast", {31'd0, irq_fast}, 32'd1);
      check("R4 irq_normal low", {31'd0, irq_normal}, 32'd0);
      bus_read(8'h0C, 4'hF, r); check("R3 normal pending empty", r, 32'd0);
      set_hw(32'h0F00_0101);
      check("R6 irq_fast masked", {31'd0, irq_fast}, 32'd0);
      bus_write(8'h08, 32'd0, 4'hF);
      set_hw('0);
   endtask

   task automatic t_both_classes();
      logic [31:0] r;
      bus_write(8'h04, 32'h0000_0200, 4'hF);
      bus_write(8'h08, 32'h0000_0200, 4'hF);
      set_hw(32'h0000_0200);
      check("R12 normal from shared source", {31'd0, irq_normal}, 32'd1);
      check("R12 fast from shared source", {31'd0, irq_fast}, 32'd1);
      bus_read(8'h10, 4'hF, r); check("R12 fast pending shared", r, 32'h0000_0200);
      set_hw('0);
      check("R12 normal drops", {31'd0, irq_normal}, 32'd0);
      check("R12 fast drops", {31'd0, irq_fast}, 32'd0);
   endtask

   task automatic t_readonly();
      logic [31:0] r;
      bus_write(8'h04, 32'h0000_00FF, 4'hF);
      bus_write(8'h08, 32'h0000_FF00, 4'hF);
      set_hw(32'h0000_0F0F);
      bus_write(8'h00, 32'hFFFF_FFFF, 4'hF);
      bus_write(8'h0C, 32'd0, 4'hF);
      bus_write(8'h10, 32'd0, 4'hF);
      bus_read(8'h00, 4'hF, r); check("R8 source unchanged", r, 32'h0000_0F0F);
      bus_read(8'h0C, 4'hF, r); check("R8 normal pending unchanged", r, 32'h0000_000F);
      bus_read(8'h10, 4'hF, r); check("R8 fast pending unchanged", r, 32'h0000_0F00);
      bus_read(8'h04, 4'hF, r); check("R8 normal enable unchanged", r, 32'h0000_00FF);
      bus_read(8'h14, 4'hF, r); check("R8 force unchanged", r, 32'd0);
      check("R8 irq_normal", {31'd0, irq_normal}, 32'd1);
      set_hw('0);
   endtask

   task automatic t_force();
      logic [31:0] r;
      bus_write(8'h04, 32'h8000_0000, 4'hF);
      bus_write(8'h08, 32'h0000_0001, 4'hF);
      check("R9 no request before force", {31'd0, irq_normal}, 32'd0);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h8000_0001; bus_be = 4'hF;
      @(posedge clk); #1;
      check("R9 normal request right after force edge", {31'd0, irq_normal}, 32'd1);
      check("R9 fast request right after force edge", {31'd0, irq_fast}, 32'd1);
      @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
      bus_read(8'h14, 4'hF, r); check("R9 force readback", r, 32'h8000_0001);
      bus_read(8'h00, 4'hF, r); check("R9 source from force", r, 32'h8000_0001);
      bus_write(8'h14, 32'd0, 4'hF);
      check("R9 request clears", {31'd0, irq_normal}, 32'd0);
      check("R9 fast clears", {31'd0, irq_fast}, 32'd0);
   endtask

   task automatic t_partial();
      logic [31:0] r;
      bus_write(8'h04, 32'h0000_0001, 4'hF);
      bus_write(8'h04, 32'hFFFF_FFFF, 4'h3);
      bus_write(8'h14, 32'h0000_0001, 4'h1);
      bus_read(8'h04, 4'hF, r); check("R10 partial write ignored", r, 32'h0000_0001);
      check("R10 partial force ignored", {31'd0, irq_normal}, 32'd0);
      bus_read(8'h04, 4'h7, r); check("R10 partial read zero", r, 32'd0);
      bus_read(8'h14, 4'hF, r); check("R10 force still zero", r, 32'd0);
   endtask

   task automatic t_unmapped();
      logic [31:0] r;
      bus_write(8'h18, 32'hFFFF_FFFF, 4'hF);
      bus_write(8'h06, 32'hFFFF_FFFF, 4'hF);
      bus_read(8'h04, 4'hF, r); check("R11 enable unaffected", r, 32'h0000_0001);
      bus_read(8'h08, 4'hF, r); check("R11 fast enable unaffected", r, 32'h0000_0001);
      bus_read(8'h14, 4'hF, r); check("R11 force unaffected", r, 32'd0);
      bus_read(8'h18, 4'hF, r); check("R11 unmapped read zero", r, 32'd0);
      bus_read(8'h05, 4'hF, r); check("R11 misaligned read zero", r, 32'd0);
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_enable_rw();
      t_normal_path();
      t_sync_latency();
      t_fast_path();
      t_both_classes();
      t_readonly();
      t_force();
      t_partial();
      t_unmapped();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule